// File: doc/BRIEF.md
# Autovectored Interrupt Request Controller

This block connects the end-of-conversion event of an analog-to-digital converter to a processor that takes prioritised, encoded interrupt requests and reads vectors during an acknowledge bus cycle. A completed conversion sets a pending flag. While that flag is set, the block drives the three active-low priority lines with a fixed level, 4 by default. When the processor runs an acknowledge cycle for that level, the block answers with the valid-peripheral-address response rather than a data acknowledge. The processor then builds the autovector itself: vector 24 plus the level, which is vector 28 at level 4, with its table entry at byte offset $70.

The pending flag is not cleared by the acknowledge. It clears when the service routine reads the converted byte, which the address decoder reports on a read strobe. The routine then starts a new conversion, and the next completion raises the request again. All inputs are assumed synchronous to the block clock. The active-low reset is synchronous.

Top module: `irq_autovec_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `ipl_n` is 3'b111 and `vpa_n` is 1.
- R2: A rising edge of `eoc` (high at a clock edge, low at the edge before) sets the request. From that edge on, `ipl_n` equals the bitwise inverse of the level: 3'b011 for level 4.
- R3: Once set, the request stays on `ipl_n` through any number of acknowledge cycles, until R6 clears it.
- R4: An acknowledge for the block's level is `as_n`=0, `fc`=3'b111 and `addr_lo` (A3..A1)=3'b100. `vpa_n` drops at the clock edge that samples such a cycle. It rises at the first edge that samples `as_n`=1.
- R5: If `fc` is not 3'b111, or `addr_lo` differs from the level, `vpa_n` stays 1 in the following cycle, even with `as_n`=0.
- R6: A rising edge of `rd_data` with no rising edge of `eoc` in the same cycle clears the request. `ipl_n` returns to 3'b111 from that edge on.
- R7: If rising edges of `eoc` and `rd_data` fall in the same cycle, the request stays set and is not lost.
- R8: Holding `eoc` high does not set the request again after it has been cleared. Only a fresh rising edge sets it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| eoc | input | 1 | Converter end-of-conversion, active high |
| as_n | input | 1 | Processor address strobe, active low |
| fc | input | 3 | Processor function code |
| addr_lo | input | 3 | Address bits A3..A1 |
| rd_data | input | 1 | Decoder strobe for a read of the converter data register, active high |
| ipl_n | output | 3 | Encoded interrupt priority lines, active low |
| vpa_n | output | 1 | Valid-peripheral-address response for autovectoring, active low |

## Verification
The bench sends acknowledge cycles while a request is pending. A design that cleared on the acknowledge would drop `ipl_n` and lose the data read. Acknowledges for other levels and other function codes are also tried. A decoder that ignored `fc` or `addr_lo` would answer with `vpa_n` for cycles it does not own. Completion and data read are made to coincide, and `eoc` is held high across a clear. Here a wrong set/clear priority loses a conversion, and level sensitivity causes a spurious second interrupt. Random stimulus then mixes all inputs against a bench model of the request and the response.

// File: rtl/irq_pkg.sv
// Package irq_pkg
// Shared widths and codes for the autovectored interrupt controller.
// Assumes a three-line encoded priority bus and three function-code bits.
package irq_pkg;
    localparam int IPL_W      = 3;
    localparam int FC_W       = 3;
    localparam int AUTO_BASE  = 24;
    localparam logic [FC_W-1:0] FC_IACK = 3'b111;
endpackage

// File: rtl/irq_pend_latch.sv
// Module irq_pend_latch
// Holds the pending converter request. It sets on a rising edge of the
// completion input and clears on a rising edge of the data-read strobe.
// When both edges meet, set wins. Assumes synchronous inputs.
module irq_pend_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic eoc,
    input  logic rd_data,
    output logic pend
);
    logic eoc_d;
    logic rd_d;
    logic eoc_rise;
    logic rd_rise;

    // Edge detection on both event inputs
    assign eoc_rise = eoc & ~eoc_d;
    assign rd_rise  = rd_data & ~rd_d;

    // Delay registers for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eoc_d <= 1'b0;
            rd_d  <= 1'b0;
        end else begin
            eoc_d <= eoc;
            rd_d  <= rd_data;
        end
    end

    // Pending flag: completion has priority over the clear
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend <= 1'b0;
        else if (eoc_rise)
            pend <= 1'b1;
        else if (rd_rise)
            pend <= 1'b0;
    end

    p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        eoc_rise |=> pend);
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !rd_rise) |=> pend);
    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_rise && !eoc_rise) |=> !pend);
    p_coincide_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_rise && eoc_rise) |=> pend);
    p_noretrig_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend && eoc && eoc_d) |=> !pend);
endmodule

// File: rtl/irq_level_enc.sv
// Module irq_level_enc
// Drives the active-low priority lines with the fixed level while a request
// is pending, and all ones otherwise. Assumes LEVEL is between 1 and 7.
module irq_level_enc
    import irq_pkg::*;
#(
    parameter int LEVEL = 4
) (
    input  logic             pend,
    output logic [IPL_W-1:0] ipl_n
);
    localparam logic [IPL_W-1:0] LVL = IPL_W'(LEVEL);

    // One line per priority bit; a set level bit pulls its line low
    for (genvar gi = 0; gi < IPL_W; gi++) begin : g_line
        assign ipl_n[gi] = pend ? ~LVL[gi] : 1'b1;
    end
endmodule

// File: rtl/irq_iack_resp.sv
// Module irq_iack_resp
// Spots an acknowledge cycle for the block's level. Through a registered
// output it asserts the valid-peripheral-address response until the strobe
// negates. Other levels and ordinary bus cycles get no response.
module irq_iack_resp
    import irq_pkg::*;
#(
    parameter int LEVEL = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            as_n,
    input  logic [FC_W-1:0] fc,
    input  logic [2:0]      addr_lo,
    output logic            vpa_n
);
    localparam logic [2:0] LVL_ADDR = 3'(LEVEL);

    logic hit;

    // Acknowledge match for this level
    assign hit = !as_n && (fc == FC_IACK) && (addr_lo == LVL_ADDR);

    // Registered response, released when the strobe is sampled high
    always_ff @(posedge clk) begin
        if (!rst_n)
            vpa_n <= 1'b1;
        else
            vpa_n <= ~hit;
    end

    p_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        as_n |=> vpa_n);
    p_other_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((fc != FC_IACK) || (addr_lo != LVL_ADDR)) |=> vpa_n);
endmodule

// File: rtl/irq_autovec_ctrl.sv
// Module irq_autovec_ctrl
// Top level of the converter interrupt path. It latches completion, drives
// the fixed priority, and answers the matching acknowledge with an
// autovector response. The vector is AUTO_BASE + LEVEL, so 28 at level 4.
// Assumes all inputs are synchronous to clk.
module irq_autovec_ctrl
    import irq_pkg::*;
#(
    parameter int LEVEL = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             eoc,
    input  logic             as_n,
    input  logic [FC_W-1:0]  fc,
    input  logic [2:0]       addr_lo,
    input  logic             rd_data,
    output logic [IPL_W-1:0] ipl_n,
    output logic             vpa_n
);
    localparam int VECTOR = AUTO_BASE + LEVEL;
    localparam logic [IPL_W-1:0] IPL_ON = ~IPL_W'(LEVEL);

    logic pend;

    irq_pend_latch u_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .eoc     (eoc),
        .rd_data (rd_data),
        .pend    (pend)
    );

    irq_level_enc #(.LEVEL(LEVEL)) u_enc (
        .pend  (pend),
        .ipl_n (ipl_n)
    );

    irq_iack_resp #(.LEVEL(LEVEL)) u_iack (
        .clk     (clk),
        .rst_n   (rst_n),
        .as_n    (as_n),
        .fc      (fc),
        .addr_lo (addr_lo),
        .vpa_n   (vpa_n)
    );

    initial begin
        assert (LEVEL >= 1 && LEVEL <= 7 && VECTOR == AUTO_BASE + LEVEL);
    end

    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (ipl_n == '1 && vpa_n));
    p_lines_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ipl_n == (pend ? IPL_ON : '1));
endmodule

// File: tb/test_irq_autovec_ctrl.sv
`timescale 1ns/1ps
module test_irq_autovec_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       eoc = 1'b0;
    logic       as_n = 1'b1;
    logic [2:0] fc = 3'b000;
    logic [2:0] addr_lo = 3'b000;
    logic       rd_data = 1'b0;
    logic [2:0] ipl_n;
    logic       vpa_n;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    irq_autovec_ctrl #(.LEVEL(4)) i_irq_autovec_ctrl (
        .clk(clk), .rst_n(rst_n), .eoc(eoc), .as_n(as_n), .fc(fc),
        .addr_lo(addr_lo), .rd_data(rd_data), .ipl_n(ipl_n), .vpa_n(vpa_n)
    );

    // Bench model of the requirements
    logic m_pend, m_eoc_d, m_rd_d, m_vpa_n;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_pend <= 1'b0; m_eoc_d <= 1'b0; m_rd_d <= 1'b0; m_vpa_n <= 1'b1;
        end else begin
            m_eoc_d <= eoc;
            m_rd_d  <= rd_data;
            if (eoc && !m_eoc_d)          m_pend <= 1'b1;
            else if (rd_data && !m_rd_d)  m_pend <= 1'b0;
            m_vpa_n <= exp_vpa(as_n, fc, addr_lo);
        end
    end

    function automatic logic [2:0] exp_ipl(input logic p);
        return p ? 3'b011 : 3'b111;
    endfunction

    function automatic logic exp_vpa(input logic a, input logic [2:0] f,
                                     input logic [2:0] ad);
        return !(!a && f == 3'b111 && ad == 3'b100);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic e, input logic r, input logic a,
                         input logic [2:0] f, input logic [2:0] ad);
        eoc = e; rd_data = r; as_n = a; fc = f; addr_lo = ad;
        @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 ipl_n in reset", 32'(ipl_n), 32'h7);
        chk("R1 vpa_n in reset", 32'(vpa_n), 32'h1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ipl_n after reset", 32'(ipl_n), 32'h7);
        chk("R1 vpa_n after reset", 32'(vpa_n), 32'h1);

        drive(1, 0, 1, 3'b000, 3'b000);
        chk("R2 request raised", 32'(ipl_n), 32'h3);
        drive(0, 0, 0, 3'b111, 3'b100);
        chk("R4 vpa_n on acknowledge", 32'(vpa_n), 32'h0);
        chk("R3 request kept in acknowledge", 32'(ipl_n), 32'h3);
        drive(0, 0, 0, 3'b111, 3'b100);
        chk("R4 vpa_n held while strobe low", 32'(vpa_n), 32'h0);
        drive(0, 0, 1, 3'b111, 3'b100);
        chk("R4 vpa_n released", 32'(vpa_n), 32'h1);
        chk("R3 request kept after acknowledge", 32'(ipl_n), 32'h3);
        drive(0, 0, 0, 3'b111, 3'b010);
        chk("R5 other level ignored", 32'(vpa_n), 32'h1);
        drive(0, 0, 0, 3'b101, 3'b100);
        chk("R5 non-acknowledge code ignored", 32'(vpa_n), 32'h1);
        drive(0, 0, 1, 3'b000, 3'b000);
        drive(0, 1, 1, 3'b000, 3'b000);
        chk("R6 read clears request", 32'(ipl_n), 32'h7);
        drive(0, 0, 1, 3'b000, 3'b000);

        drive(1, 0, 1, 3'b000, 3'b000);
        chk("R2 second request", 32'(ipl_n), 32'h3);
        drive(1, 1, 1, 3'b000, 3'b000);
        chk("R6 clear with eoc still high", 32'(ipl_n), 32'h7);
        drive(1, 0, 1, 3'b000, 3'b000);
        drive(1, 0, 1, 3'b000, 3'b000);
        chk("R8 held eoc does not retrigger", 32'(ipl_n), 32'h7);
        drive(0, 0, 1, 3'b000, 3'b000);
        drive(1, 1, 1, 3'b000, 3'b000);
        chk("R7 coincident set and clear", 32'(ipl_n), 32'h3);
        drive(0, 0, 1, 3'b000, 3'b000);
        drive(0, 1, 1, 3'b000, 3'b000);
        chk("R6 clear after coincidence", 32'(ipl_n), 32'h7);

        void'($urandom(32'd1234));
        for (int i = 0; i < 4000; i++) begin
            logic e, r, a;
            logic [2:0] f, ad;
            e = ($urandom % 4) == 0;
            r = ($urandom % 5) == 0;
            a = ($urandom % 3) != 0;
            f = ($urandom % 2) ? 3'b111 : 3'($urandom);
            ad = ($urandom % 2) ? 3'b100 : 3'($urandom);
            drive(e, r, a, f, ad);
            chk("R2/R6 random ipl_n", 32'(ipl_n), 32'(exp_ipl(m_pend)));
            chk("R4/R5 random vpa_n", 32'(vpa_n), 32'(m_vpa_n));
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule